// File: doc/BRIEF.md
# Adaptive Set Ownership Manager

This block tracks which processor holds replacement rights over each set of a shared cache. For every set it keeps an owner id and a small saturating confidence counter. The owner keeps the set while its confidence stays above zero. Other processors that keep missing on the set lower that confidence. When it runs out, the set is released, and the next processor that misses on it can claim it.

Each cycle the block may receive one lookup-result event. The event carries a set index, the requester id, a hit flag for the shared set and a hit flag for the private overflow caches. The block returns the owner of the indexed set as it stands before the event is applied. The replacement logic beside it uses that owner to decide whether the requester may evict from the set or must use its overflow cache. In the cycle in which a set loses its owner, the block raises a one-cycle release pulse that carries the set index.

Each set runs a two-state machine. The states are FREE and HELD. The CLAIM transition moves a set from FREE to HELD. The RELEASE transition moves it from HELD to FREE. In HELD, the transitions BOOST (a hit in the shared set) and ERODE (a miss in both places by a non-owner) step the counter. Every other event leaves the set as it is. The event is first sorted into one of these kinds: IDLE, HIT, OVF, CLAIM, OWN_MISS, FOREIGN.

Top module: `set_owner_mgr`

## Requirements
- R1: After reset every set is unowned, `own_valid` and `own_id` read 0 for every index, and `rel_pulse` is 0.
- R2: `own_valid` and `own_id` show, combinationally, the ownership of set `evt_set` as it was before the current cycle's event. This holds whether `evt_valid` is high or low. `own_id` is 0 whenever `own_valid` is 0.
- R3: A valid event that misses in both the set and the overflow caches, on an unowned set, makes the requester the owner from the next cycle on. The confidence counter starts at 4.
- R4: A valid event with `evt_set_hit`=1 on an owned set raises the confidence by one, up to a ceiling of 7. From 7, exactly seven non-owner double misses release the set.
- R5: A valid double miss from a non-owner lowers the confidence by one. The miss that brings it to zero clears the owner, so a freshly claimed set is released by its fourth such miss.
- R6: A valid double miss from the owner leaves the owner and the confidence unchanged.
- R7: A valid event with `evt_set_hit`=0 and `evt_ovf_hit`=1 changes neither the owner nor the confidence, whoever the requester is.
- R8: In the cycle after a releasing event, `rel_pulse` is 1 for exactly one cycle and `rel_set` equals that event's set index. At all other times `rel_pulse` is 0.
- R9: The miss that releases a set does not also claim it. The set reads unowned until a later qualifying miss claims it.
- R10: With `evt_valid`=0, no set changes state.
- R11: A valid event with `evt_set_hit`=1 on an unowned set does not claim it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | A lookup-result event is present this cycle |
| evt_set | input | 4 | Set index of the event (also the index looked up) |
| evt_req | input | 2 | Id of the requesting processor |
| evt_set_hit | input | 1 | The reference hit in the shared set |
| evt_ovf_hit | input | 1 | The reference hit in some overflow cache |
| own_valid | output | 1 | The indexed set currently has an owner |
| own_id | output | 2 | Owner id of the indexed set, 0 when unowned |
| rel_pulse | output | 1 | One-cycle pulse: a set lost its owner at the last edge |
| rel_set | output | 4 | Index of the released set while `rel_pulse` is 1 |

## Verification
Several rules are checked on every cycle at the ports. A release may only follow a non-owner double miss, and its index must match. A cleared owner must read id 0. A claim must be visible on the next event to the same set. An owner miss, an overflow hit or a set hit must leave the next lookup of that set with the same owner. The confidence value is not visible at the ports, so its exact count can only be shown by the bench's scenarios. These count how many non-owner misses release a set after a claim, after saturating hits, and after runs of owner misses, overflow hits and idle cycles. A long mixed sweep is also compared against an arithmetic model of every set.

// File: rtl/set_own_pkg.sv
package set_own_pkg;

    // Classification of one lookup-result event against its set's owner
    typedef enum logic [2:0] {
        K_IDLE     = 3'd0,
        K_HIT      = 3'd1,
        K_OVF      = 3'd2,
        K_CLAIM    = 3'd3,
        K_OWN_MISS = 3'd4,
        K_FOREIGN  = 3'd5
    } evt_kind_t;

    // Per-set ownership state
    typedef enum logic {
        ST_FREE = 1'b0,
        ST_HELD = 1'b1
    } slot_state_t;

endpackage

// File: rtl/set_own_classify.sv
module set_own_classify
    import set_own_pkg::*;
#(
    parameter int ID_W = 2
) (
    input  logic            valid_i,
    input  logic            set_hit_i,
    input  logic            ovf_hit_i,
    input  logic            own_valid_i,
    input  logic [ID_W-1:0] own_id_i,
    input  logic [ID_W-1:0] req_i,
    output evt_kind_t       kind_o
);

    always_comb begin
        if (!valid_i) begin
            kind_o = K_IDLE;
        end else if (set_hit_i) begin
            kind_o = K_HIT;
        end else if (ovf_hit_i) begin
            kind_o = K_OVF;
        end else if (!own_valid_i) begin
            kind_o = K_CLAIM;
        end else if (own_id_i == req_i) begin
            kind_o = K_OWN_MISS;
        end else begin
            kind_o = K_FOREIGN;
        end
    end

endmodule

// File: rtl/set_own_slot.sv
module set_own_slot
    import set_own_pkg::*;
#(
    parameter int ID_W      = 2,
    parameter int CONF_W    = 3,
    parameter int CONF_INIT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_i,
    input  evt_kind_t       kind_i,
    input  logic [ID_W-1:0] req_i,
    output logic            held_o,
    output logic [ID_W-1:0] owner_o,
    output logic            rel_o
);

    localparam logic [CONF_W-1:0] CONF_MAX   = '1;
    localparam logic [CONF_W-1:0] CONF_START = CONF_W'(CONF_INIT);
    localparam logic [CONF_W-1:0] CONF_ONE   = CONF_W'(1);

    slot_state_t       st_q, st_n;
    logic [CONF_W-1:0] conf_q, conf_n;
    logic [ID_W-1:0]   own_q, own_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_FREE;
            conf_q <= '0;
            own_q  <= '0;
        end else begin
            st_q   <= st_n;
            conf_q <= conf_n;
            own_q  <= own_n;
        end
    end

    // Transitions: CLAIM, BOOST, ERODE, RELEASE
    always_comb begin
        st_n   = st_q;
        conf_n = conf_q;
        own_n  = own_q;
        rel_o  = 1'b0;
        if (sel_i) begin
            unique case (st_q)
                ST_FREE: begin
                    if (kind_i == K_CLAIM) begin
                        st_n   = ST_HELD;
                        own_n  = req_i;
                        conf_n = CONF_START;
                    end
                end
                ST_HELD: begin
                    case (kind_i)
                        K_HIT: begin
                            if (conf_q != CONF_MAX) conf_n = conf_q + CONF_ONE;
                        end
                        K_FOREIGN: begin
                            if (conf_q <= CONF_ONE) begin
                                st_n   = ST_FREE;
                                conf_n = '0;
                                own_n  = '0;
                                rel_o  = 1'b1;
                            end else begin
                                conf_n = conf_q - CONF_ONE;
                            end
                        end
                        default: ;
                    endcase
                end
            endcase
        end
    end

    assign held_o  = (st_q == ST_HELD);
    assign owner_o = own_q;

endmodule

// File: rtl/set_own_lookup.sv
module set_own_lookup #(
    parameter int NSETS = 16,
    parameter int ID_W  = 2,
    localparam int IDX_W = $clog2(NSETS)
) (
    input  logic [NSETS-1:0]      held_i,
    input  logic [NSETS*ID_W-1:0] owner_i,
    input  logic [IDX_W-1:0]      idx_i,
    output logic                  own_valid_o,
    output logic [ID_W-1:0]       own_id_o
);

    always_comb begin
        own_valid_o = 1'b0;
        own_id_o    = '0;
        for (int i = 0; i < NSETS; i++) begin
            if (idx_i == IDX_W'(i) && held_i[i]) begin
                own_valid_o = 1'b1;
                own_id_o    = owner_i[i*ID_W +: ID_W];
            end
        end
    end

endmodule

// File: rtl/set_owner_mgr.sv
module set_owner_mgr
    import set_own_pkg::*;
#(
    parameter int NSETS     = 16,
    parameter int NPROCS    = 4,
    parameter int CONF_W    = 3,
    parameter int CONF_INIT = 4,
    localparam int IDX_W = $clog2(NSETS),
    localparam int ID_W  = $clog2(NPROCS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic [IDX_W-1:0] evt_set,
    input  logic [ID_W-1:0]  evt_req,
    input  logic             evt_set_hit,
    input  logic             evt_ovf_hit,
    output logic             own_valid,
    output logic [ID_W-1:0]  own_id,
    output logic             rel_pulse,
    output logic [IDX_W-1:0] rel_set
);

    logic [NSETS-1:0]      held_vec;
    logic [NSETS*ID_W-1:0] owner_vec;
    logic [NSETS-1:0]      rel_vec;
    evt_kind_t             kind;

    set_own_lookup #(.NSETS(NSETS), .ID_W(ID_W)) u_lookup (
        .held_i      (held_vec),
        .owner_i     (owner_vec),
        .idx_i       (evt_set),
        .own_valid_o (own_valid),
        .own_id_o    (own_id)
    );

    set_own_classify #(.ID_W(ID_W)) u_classify (
        .valid_i     (evt_valid),
        .set_hit_i   (evt_set_hit),
        .ovf_hit_i   (evt_ovf_hit),
        .own_valid_i (own_valid),
        .own_id_i    (own_id),
        .req_i       (evt_req),
        .kind_o      (kind)
    );

    for (genvar g = 0; g < NSETS; g++) begin : g_slot
        logic sel;
        assign sel = evt_valid && (evt_set == IDX_W'(g));
        set_own_slot #(
            .ID_W      (ID_W),
            .CONF_W    (CONF_W),
            .CONF_INIT (CONF_INIT)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_i   (sel),
            .kind_i  (kind),
            .req_i   (evt_req),
            .held_o  (held_vec[g]),
            .owner_o (owner_vec[g*ID_W +: ID_W]),
            .rel_o   (rel_vec[g])
        );
    end

    // Release reporting register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_pulse <= 1'b0;
            rel_set   <= '0;
        end else begin
            rel_pulse <= |rel_vec;
            rel_set   <= (|rel_vec) ? evt_set : '0;
        end
    end

endmodule

// File: rtl/set_own_chk.sv
module set_own_chk #(
    parameter int IDX_W = 4,
    parameter int ID_W  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_valid,
    input logic [IDX_W-1:0] evt_set,
    input logic [ID_W-1:0]  evt_req,
    input logic             evt_set_hit,
    input logic             evt_ovf_hit,
    input logic             own_valid,
    input logic [ID_W-1:0]  own_id,
    input logic             rel_pulse,
    input logic [IDX_W-1:0] rel_set
);

    logic foreign_miss, dbl_miss;
    assign dbl_miss     = evt_valid && !evt_set_hit && !evt_ovf_hit;
    assign foreign_miss = dbl_miss && own_valid && (own_id != evt_req);

    // R2
    idle_id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !own_valid |-> own_id == '0);

    // R8
    rel_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_pulse |-> $past(foreign_miss) && rel_set == $past(evt_set));

    // R3
    claim_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dbl_miss && !own_valid) && evt_set == $past(evt_set))
        |-> own_valid && own_id == $past(evt_req));

    // R6
    owner_miss_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dbl_miss && own_valid && own_id == evt_req) && evt_set == $past(evt_set))
        |-> own_valid && own_id == $past(own_id));

    // R7
    ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_valid && !evt_set_hit && evt_ovf_hit) && evt_set == $past(evt_set))
        |-> own_valid == $past(own_valid) && own_id == $past(own_id));

    // R4
    hit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt_valid && evt_set_hit) && evt_set == $past(evt_set))
        |-> own_valid == $past(own_valid) && own_id == $past(own_id));

    // R10
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!evt_valid) && evt_set == $past(evt_set))
        |-> own_valid == $past(own_valid) && own_id == $past(own_id));

endmodule

bind set_owner_mgr set_own_chk #(.IDX_W(IDX_W), .ID_W(ID_W)) u_set_own_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid   (evt_valid),
    .evt_set     (evt_set),
    .evt_req     (evt_req),
    .evt_set_hit (evt_set_hit),
    .evt_ovf_hit (evt_ovf_hit),
    .own_valid   (own_valid),
    .own_id      (own_id),
    .rel_pulse   (rel_pulse),
    .rel_set     (rel_set)
);

// File: tb/test_set_owner_mgr.sv
`timescale 1ns/1ps
module test_set_owner_mgr;

    localparam int NS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_valid = 1'b0;
    logic [3:0] evt_set = '0;
    logic [1:0] evt_req = '0;
    logic       evt_set_hit = 1'b0;
    logic       evt_ovf_hit = 1'b0;
    logic       own_valid;
    logic [1:0] own_id;
    logic       rel_pulse;
    logic [3:0] rel_set;

    int checks = 0;
    int errors = 0;

    // Bench model of the ownership policy
    bit      m_v  [NS];
    int      m_id [NS];
    int      m_cf [NS];

    always #2.5 clk = ~clk;

    set_owner_mgr i_set_owner_mgr (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_set(evt_set),
        .evt_req(evt_req), .evt_set_hit(evt_set_hit), .evt_ovf_hit(evt_ovf_hit),
        .own_valid(own_valid), .own_id(own_id), .rel_pulse(rel_pulse), .rel_set(rel_set)
    );

    task automatic check(bit ok, string tag, string act, string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // Drive one event, check lookup before the edge and release after it
    task automatic ev(int s, int r, bit v, bit sh, bit oh, string tag);
        bit exp_rel = 1'b0;
        int eid;
        @(negedge clk);
        evt_valid = v; evt_set = 4'(s); evt_req = 2'(r);
        evt_set_hit = sh; evt_ovf_hit = oh;
        #1;
        eid = m_v[s] ? m_id[s] : 0;
        check(own_valid == m_v[s] && int'(own_id) == eid, {tag, " R2 lookup"},
              $sformatf("v=%0d id=%0d", own_valid, own_id),
              $sformatf("v=%0d id=%0d", m_v[s], eid));
        if (v) begin
            if (sh) begin
                if (m_v[s] && m_cf[s] < 7) m_cf[s]++;
            end else if (!oh) begin
                if (!m_v[s]) begin
                    m_v[s] = 1'b1; m_id[s] = r; m_cf[s] = 4;
                end else if (m_id[s] != r) begin
                    m_cf[s]--;
                    if (m_cf[s] == 0) begin
                        m_v[s] = 1'b0; m_id[s] = 0; exp_rel = 1'b1;
                    end
                end
            end
        end
        @(posedge clk);
        #1;
        check(rel_pulse == exp_rel && (!exp_rel || int'(rel_set) == s), {tag, " R8 release"},
              $sformatf("p=%0d set=%0d", rel_pulse, rel_set),
              $sformatf("p=%0d set=%0d", exp_rel, s));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin m_v[i] = 0; m_id[i] = 0; m_cf[i] = 0; end
        repeat (3) @(posedge clk);
        #1;
        check(rel_pulse == 1'b0, "R1 reset pulse", $sformatf("%0d", rel_pulse), "0");
        rst_n = 1'b1;
        // R1: every set unowned after reset (idle lookups)
        for (int i = 0; i < NS; i++) ev(i, 0, 0, 0, 0, "R1");
        // R3: claim every set, owner = set mod 4
        for (int i = 0; i < NS; i++) ev(i, i % 4, 1, 0, 0, "R3");
        for (int i = 0; i < NS; i++) ev(i, 0, 0, 0, 0, "R3 readback");
        // R5: set 0 owned by 0, fourth foreign miss releases
        for (int k = 0; k < 4; k++) ev(0, 1 + (k % 3), 1, 0, 0, "R5");
        // R9: set stays unowned until a later miss claims it
        ev(0, 2, 0, 0, 0, "R9 unowned");
        ev(0, 2, 1, 0, 0, "R9 claim");
        ev(0, 3, 0, 0, 0, "R9 owner");
        // R4: saturating hits then seven foreign misses
        for (int k = 0; k < 10; k++) ev(1, k % 4, 1, 1, 0, "R4 boost");
        for (int k = 0; k < 7; k++) ev(1, 0, 1, 0, 0, "R4 erode");
        // R6: owner misses do not move the counter
        for (int k = 0; k < 20; k++) ev(2, 2, 1, 0, 0, "R6");
        for (int k = 0; k < 4; k++) ev(2, 1, 1, 0, 0, "R6 erode");
        // R7: overflow hits from anyone do not move the counter
        for (int k = 0; k < 20; k++) ev(3, k % 4, 1, 0, 1, "R7");
        for (int k = 0; k < 4; k++) ev(3, 0, 1, 0, 0, "R7 erode");
        // R10: idle cycles carrying foreign misses change nothing
        for (int k = 0; k < 20; k++) ev(4, 1, 0, 0, 0, "R10");
        for (int k = 0; k < 4; k++) ev(4, 2, 1, 0, 0, "R10 erode");
        // R11: set hit on an unowned set (set 4 now free) does not claim
        ev(4, 3, 1, 1, 0, "R11 hit");
        ev(4, 3, 0, 0, 0, "R11 check");
        // Mixed sweep against the model
        for (int k = 0; k < 4000; k++) begin
            int s  = $urandom_range(0, 7);
            int r  = $urandom_range(0, 3);
            int sel = $urandom_range(0, 9);
            ev(s, r, sel != 0, sel >= 7, sel == 6, "R3 R4 R5 R6 R7 sweep");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule